// File: doc/BRIEF.md
# Serial line-state run-length detector

The block watches a recovered serial bit stream, one bit per clock, and classifies the condition of the line from the spacing of its transitions. It needs no symbol or byte framing. An interval is the number of consecutive equal samples between two transitions. Runs of exactly 10 bit-times mark the Master condition. Runs of exactly 5 mark the Halt condition. Runs of 1 to 3 are ordinary data. A long static low level is a dark (Quiet) line.

Because only run lengths are measured, every alignment of the pattern against any symbol boundary is recognised the same way. The same holds for either starting level. The block reports a 2-bit line-state code, a one-cycle strobe whenever that code changes, and a one-cycle violation flag for spacings that no valid line condition produces. Clock recovery, symbol decoding and link-layer handling sit outside the block.

Top module: `lsd_line_state`

## Requirements
- R1: While reset is asserted and after its release, state_o is 0 (Active), chg_o and viol_o are 0, and all run and match counters are cleared.
- R2: The run in progress at reset release is not classified. The first transition after reset sets state_o to Active with viol_o low, and interval measurement starts from that transition.
- R3: state_o becomes 2 (Master) after MATCH_N (default 4) consecutive intervals of exactly 10 bit-times, at any bit alignment and starting level. The change appears after the edge that samples the first bit of the run that follows the last matching interval.
- R4: state_o becomes 3 (Halt) after MATCH_N consecutive intervals of exactly 5 bit-times, under the same alignment and timing rules as R3.
- R5: An interval of 1 to 3 bit-times sets state_o to Active without a violation and clears the match streak.
- R6: An interval of 4, 6 to 9, or 11 to QUIET_LEN-1 bit-times sets state_o to Active and raises viol_o for exactly one cycle, in the same cycle.
- R7: After the edge that samples the QUIET_LEN-th (default 16) consecutive low bit, state_o is 1 (Quiet). Bits are counted from the first sample after reset. Quiet holds while the input stays low, and the next transition returns the line to Active without a violation.
- R8: A static high input lasting QUIET_LEN bit-times raises viol_o for one cycle and sets Active. The transition that later ends that run raises no further violation.
- R9: chg_o is high for one cycle exactly when state_o takes a new value, in the same cycle, and is low otherwise.
- R10: The run counter saturates. An arbitrarily long static level keeps state_o unchanged after the first report and never repeats chg_o or viol_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock, one serial bit per rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sd_i | input | 1 | Recovered serial data bit |
| state_o | output | 2 | Line state: 0 Active, 1 Quiet, 2 Master, 3 Halt |
| chg_o | output | 1 | One-cycle strobe when state_o changes |
| viol_o | output | 1 | One-cycle flag for an illegal transition spacing |

## Verification
The bench targets pattern alignment. Every run length from 1 to 20 is swept at every phase against the reset point and from both starting levels. A design that used framed positions would miss Master or Halt at some phases, and one that classified the partial first run would report a false Master or a false violation. The boundaries next to the legal spacings (4, 6, 9, 11 and QUIET_LEN-1 against QUIET_LEN) are covered. An off-by-one run counter would flag data as a violation or report Quiet a bit early or late. Long static periods are run well past saturation: a wrapping counter would re-fire the strobe or fall out of Quiet. A high static run followed by its closing transition catches a double violation report.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  typedef enum logic [1:0] {
    LS_ACTIVE = 2'd0,
    LS_QUIET  = 2'd1,
    LS_MASTER = 2'd2,
    LS_HALT   = 2'd3
  } line_state_e;

  typedef enum logic [2:0] {
    IV_DATA,
    IV_HALT,
    IV_MASTER,
    IV_BAD,
    IV_LONG
  } ivl_kind_e;
endpackage

// File: rtl/lsd_run_tracker.sv
module lsd_run_tracker #(
  parameter int QUIET_LEN = 16,
  localparam int CW = $clog2(QUIET_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sd_i,
  output logic          trans_o,
  output logic          first_o,
  output logic [CW-1:0] ivl_o,
  output logic          static_hit_o
);
  localparam logic [CW-1:0] QMAX = CW'(QUIET_LEN);

  logic          init_q, last_q, seen_q;
  logic [CW-1:0] run_q, run_n;

  assign trans_o = init_q && (sd_i != last_q);
  assign first_o = trans_o && !seen_q;
  assign ivl_o   = run_q;

  // saturate at QUIET_LEN so long static periods never wrap
  always_comb begin
    if (!init_q || trans_o)   run_n = CW'(1);
    else if (run_q == QMAX)   run_n = QMAX;
    else                      run_n = run_q + CW'(1);
  end

  assign static_hit_o = init_q && !trans_o && (run_q != QMAX) && (run_n == QMAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b0;
      last_q <= 1'b0;
      seen_q <= 1'b0;
      run_q  <= '0;
    end else begin
      init_q <= 1'b1;
      last_q <= sd_i;
      run_q  <= run_n;
      if (trans_o) seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/lsd_ivl_class.sv
module lsd_ivl_class
  import lsd_pkg::*;
#(
  parameter int QUIET_LEN  = 16,
  parameter int DATA_MAX   = 3,
  parameter int HALT_LEN   = 5,
  parameter int MASTER_LEN = 10,
  localparam int CW = $clog2(QUIET_LEN + 1)
) (
  input  logic [CW-1:0] ivl_i,
  output ivl_kind_e     kind_o
);
  always_comb begin
    if (ivl_i <= CW'(DATA_MAX))         kind_o = IV_DATA;
    else if (ivl_i == CW'(HALT_LEN))    kind_o = IV_HALT;
    else if (ivl_i == CW'(MASTER_LEN))  kind_o = IV_MASTER;
    else if (ivl_i >= CW'(QUIET_LEN))   kind_o = IV_LONG;
    else                                kind_o = IV_BAD;
  end
endmodule

// File: rtl/lsd_match_ctr.sv
module lsd_match_ctr
  import lsd_pkg::*;
#(
  parameter int MATCH_N = 4,
  localparam int MW = $clog2(MATCH_N + 1)
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      trans_i,
  input  logic      first_i,
  input  logic      clr_i,
  input  ivl_kind_e kind_i,
  output logic      master_hit_o,
  output logic      halt_hit_o
);
  localparam logic [MW-1:0] NMAX = MW'(MATCH_N);

  ivl_kind_e     kind_q, kind_n;
  logic [MW-1:0] cnt_q, cnt_n;
  logic          is_line;

  assign is_line = (kind_i == IV_HALT) || (kind_i == IV_MASTER);

  always_comb begin
    cnt_n  = cnt_q;
    kind_n = kind_q;
    if (clr_i || first_i) begin
      cnt_n = '0;
    end else if (trans_i) begin
      if (is_line) begin
        kind_n = kind_i;
        if (kind_q == kind_i && cnt_q != '0)
          cnt_n = (cnt_q == NMAX) ? NMAX : cnt_q + MW'(1);
        else
          cnt_n = MW'(1);
      end else begin
        cnt_n = '0;
      end
    end
  end

  assign master_hit_o = trans_i && !first_i && (kind_i == IV_MASTER) && (cnt_n == NMAX);
  assign halt_hit_o   = trans_i && !first_i && (kind_i == IV_HALT)   && (cnt_n == NMAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      kind_q <= IV_DATA;
    end else begin
      cnt_q  <= cnt_n;
      kind_q <= kind_n;
    end
  end
endmodule

// File: rtl/lsd_state_fsm.sv
module lsd_state_fsm
  import lsd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sd_i,
  input  logic        trans_i,
  input  logic        first_i,
  input  logic        static_hit_i,
  input  ivl_kind_e   kind_i,
  input  logic        master_hit_i,
  input  logic        halt_hit_i,
  output line_state_e state_o,
  output logic        chg_o,
  output logic        viol_o
);
  line_state_e st_q, st_n;
  logic        chg_q, viol_q, viol_n;

  always_comb begin
    st_n   = st_q;
    viol_n = 1'b0;
    if (static_hit_i) begin
      // low static = dark line, high static = illegal
      st_n   = sd_i ? LS_ACTIVE : LS_QUIET;
      viol_n = sd_i;
    end else if (trans_i) begin
      if (first_i)           st_n = LS_ACTIVE;
      else if (master_hit_i) st_n = LS_MASTER;
      else if (halt_hit_i)   st_n = LS_HALT;
      else                   st_n = LS_ACTIVE;
      viol_n = !first_i && (kind_i == IV_BAD);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= LS_ACTIVE;
      chg_q  <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      chg_q  <= (st_n != st_q);
      viol_q <= viol_n;
    end
  end

  assign state_o = st_q;
  assign chg_o   = chg_q;
  assign viol_o  = viol_q;
endmodule

// File: rtl/lsd_line_state.sv
module lsd_line_state
  import lsd_pkg::*;
#(
  parameter int QUIET_LEN  = 16,
  parameter int MATCH_N    = 4,
  parameter int DATA_MAX   = 3,
  parameter int HALT_LEN   = 5,
  parameter int MASTER_LEN = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sd_i,
  output logic [1:0] state_o,
  output logic       chg_o,
  output logic       viol_o
);
  localparam int CW = $clog2(QUIET_LEN + 1);

  logic          trans, first, static_hit, master_hit, halt_hit;
  logic [CW-1:0] ivl;
  ivl_kind_e     kind;
  line_state_e   st;

  lsd_run_tracker #(.QUIET_LEN(QUIET_LEN)) u_run (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sd_i         (sd_i),
    .trans_o      (trans),
    .first_o      (first),
    .ivl_o        (ivl),
    .static_hit_o (static_hit)
  );

  lsd_ivl_class #(
    .QUIET_LEN  (QUIET_LEN),
    .DATA_MAX   (DATA_MAX),
    .HALT_LEN   (HALT_LEN),
    .MASTER_LEN (MASTER_LEN)
  ) u_cls (
    .ivl_i  (ivl),
    .kind_o (kind)
  );

  lsd_match_ctr #(.MATCH_N(MATCH_N)) u_match (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trans_i      (trans),
    .first_i      (first),
    .clr_i        (static_hit),
    .kind_i       (kind),
    .master_hit_o (master_hit),
    .halt_hit_o   (halt_hit)
  );

  lsd_state_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sd_i         (sd_i),
    .trans_i      (trans),
    .first_i      (first),
    .static_hit_i (static_hit),
    .kind_i       (kind),
    .master_hit_i (master_hit),
    .halt_hit_i   (halt_hit),
    .state_o      (st),
    .chg_o        (chg_o),
    .viol_o       (viol_o)
  );

  assign state_o = st;
endmodule

// File: rtl/lsd_line_state_chk.sv
module lsd_line_state_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sd_i,
  input logic [1:0] state_o,
  input logic       chg_o,
  input logic       viol_o
);
  AST_CHG_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |-> (state_o != $past(state_o))); // R9

  AST_NO_SILENT_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != $past(state_o)) |-> chg_o); // R9

  AST_VIOL_IS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> (state_o == 2'd0)); // R6

  AST_VIOL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> !viol_o); // R8

  AST_QUIET_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1) |-> ($past(sd_i) == 1'b0)); // R7
endmodule

bind lsd_line_state lsd_line_state_chk u_chk (.*);

// File: tb/sim_lsd_line_state.sv
module sim_lsd_line_state;
  localparam int QL = 16;
  localparam int MN = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sd = 1'b0;
  logic [1:0] state;
  logic       chg, viol;

  int n_run = 0, n_fail = 0, cyc = 0;
  int m_init, m_last, m_run, m_seen, s10, s5, m_state, e_chg, e_viol;
  string cur_tag = "R1";
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  lsd_line_state #(.QUIET_LEN(QL), .MATCH_N(MN)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sd_i(sd),
    .state_o(state), .chg_o(chg), .viol_o(viol)
  );

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      summary();
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference from the requirements: unbounded run, separate streaks
  task automatic model_step(input int b);
    int ns, len;
    ns = m_state; e_viol = 0;
    if (m_init == 0) begin
      m_init = 1; m_last = b; m_run = 1;
    end else if (b != m_last) begin
      len = m_run; m_last = b; m_run = 1;
      if (m_seen == 0) begin
        m_seen = 1; ns = 0; s10 = 0; s5 = 0;
      end else begin
        if (len == 10) begin s10++; s5 = 0; end
        else if (len == 5) begin s5++; s10 = 0; end
        else begin s10 = 0; s5 = 0; end
        e_viol = (len > 3 && len != 5 && len != 10 && len < QL) ? 1 : 0;
        ns = (s10 >= MN) ? 2 : (s5 >= MN) ? 3 : 0;
      end
    end else begin
      m_run++;
      if (m_run == QL) begin
        ns = b ? 0 : 1; e_viol = b; s10 = 0; s5 = 0;
      end
    end
    e_chg = (ns != m_state) ? 1 : 0;
    m_state = ns;
  endtask

  // called at a negedge, returns at the next negedge
  task automatic drive_bit(input int b);
    sd = b[0];
    @(posedge clk); #1;
    model_step(b);
    check(state == m_state[1:0], cur_tag, int'(state), m_state);
    check(chg == e_chg[0], {cur_tag, " chg R9"}, int'(chg), e_chg);
    check(viol == e_viol[0], {cur_tag, " viol"}, int'(viol), e_viol);
    @(negedge clk);
  endtask

  task automatic drive_run(input int lvl, input int len);
    for (int i = 0; i < len; i++) drive_bit(lvl);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; sd = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    m_init = 0; m_last = 0; m_run = 0; m_seen = 0;
    s10 = 0; s5 = 0; m_state = 0; e_chg = 0; e_viol = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    do_reset();
    // R1 reset state
    check(state == 2'd0, "R1 state", int'(state), 0);
    check(chg == 1'b0, "R1 chg", int'(chg), 0);
    check(viol == 1'b0, "R1 viol", int'(viol), 0);

    // R7 / R10 quiet entry, hold and exit
    do_reset(); cur_tag = "R7";
    drive_run(0, QL - 1);
    check(state == 2'd0, "R7 before", int'(state), 0);
    drive_bit(0);
    check(state == 2'd1, "R7 quiet", int'(state), 1);
    check(chg == 1'b1, "R7 R9 strobe", int'(chg), 1);
    cur_tag = "R10";
    drive_run(0, 40);
    check(state == 2'd1 && chg == 1'b0, "R10 held", int'(state), 1);
    cur_tag = "R7";
    drive_bit(1);
    check(state == 2'd0 && viol == 1'b0, "R7 exit", int'(state), 0);

    // R8 static high
    do_reset(); cur_tag = "R8";
    drive_bit(0);
    drive_run(1, QL - 1);
    drive_bit(1);
    check(viol == 1'b1, "R8 flag", int'(viol), 1);
    drive_bit(1);
    check(viol == 1'b0, "R8 one cycle", int'(viol), 0);
    drive_run(1, 30);
    drive_bit(0);
    check(viol == 1'b0, "R8 no second", int'(viol), 0);

    // R2 partial first run, then R6 bad interval
    do_reset(); cur_tag = "R2";
    drive_run(1, 7);
    drive_bit(0);
    check(viol == 1'b0, "R2 first", int'(viol), 0);
    cur_tag = "R6";
    drive_run(0, 6);
    drive_bit(1);
    check(viol == 1'b1 && state == 2'd0, "R6 seven", int'(viol), 1);

    // R3 master after four 10-intervals
    do_reset(); cur_tag = "R3";
    drive_run(0, 3);
    drive_run(1, 10); drive_run(0, 10); drive_run(1, 10);
    drive_bit(0);
    check(state == 2'd0, "R3 three", int'(state), 0);
    drive_run(0, 9);
    drive_bit(1);
    check(state == 2'd2 && chg == 1'b1, "R3 master", int'(state), 2);

    // R4 halt, then R5 data breaks it
    do_reset(); cur_tag = "R4";
    drive_run(1, 2);
    drive_run(0, 5); drive_run(1, 5); drive_run(0, 5); drive_run(1, 5);
    drive_bit(0);
    check(state == 2'd3, "R4 halt", int'(state), 3);
    cur_tag = "R5";
    drive_bit(0);
    drive_bit(1);
    check(state == 2'd0 && viol == 1'b0, "R5 data", int'(state), 0);

    // alignment sweep: every length, phase and start level
    for (int st = 0; st < 2; st++) begin
      for (int len = 1; len <= 20; len++) begin
        for (int ph = 0; ph < len; ph++) begin
          do_reset();
          if (len <= 3) cur_tag = "R5";
          else if (len == 5) cur_tag = "R4";
          else if (len == 10) cur_tag = "R3";
          else if (len >= QL) cur_tag = "R8";
          else cur_tag = "R6";
          drive_run(st, ph + 1);
          for (int k = 0; k < 8; k++) drive_run(((st + k + 1) % 2), len);
          drive_run(st, 2);
          drive_run(1 - st, 1);
          cur_tag = "R7";
          drive_run(0, QL + 2);
          drive_bit(1);
        end
      end
    end

    // mixed pseudo-random run lengths
    do_reset(); cur_tag = "R9";
    begin
      int lvl, len, reps;
      lvl = 0;
      for (int r = 0; r < 1500; r++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (lfsr[2:0])
          3'd0: len = 1;
          3'd1: len = 2;
          3'd2: len = 3;
          3'd3, 3'd7: len = 5;
          3'd4, 3'd5: len = 10;
          default: len = 4 + int'(lfsr[7:4]);
        endcase
        reps = lfsr[8] ? 5 : 1;
        for (int q = 0; q < reps; q++) begin
          drive_run(lvl, len);
          lvl = 1 - lvl;
        end
      end
    end

    summary();
  end
endmodule